// File: doc/BRIEF.md
# Synchronous Burst Static RAM

A clocked static RAM with 32-bit words split into four 8-bit byte lanes. Every control, address and data input is sampled on the rising clock edge. An access starts when the chip is selected and either of two address strobes is asserted: a processor-side strobe or a controller-side strobe. Once an access has started, each following selected cycle continues the burst. A cycle with the advance input asserted steps the word address in linear order within an aligned group of four words. A cycle without it repeats the current word.

Each access is either a read or a write. The write controls choose between a full-word write, a write to selected byte lanes, or a read. Read data is registered and appears one clock after the access cycle. It is qualified by an output-enable input and a valid flag that stands in for the tristate state of a real data pin.

Top module: `sync_burst_sram`

## Requirements
- R1: The chip is selected only when `cs1_n`=0, `cs2`=1 and `cs3_n`=0. In a cycle with any other combination, no access takes place and memory is not changed.
- R2: In a selected cycle with `pstrb_n`=0 or `cstrb_n`=0, the access uses `addr` and that address becomes the burst base. Because `cs1_n`=1 deselects the chip, the processor strobe has no effect then.
- R3: A read access places the addressed word on `dout` with `dout_valid`=1 in the clock cycle after the access edge, provided `oe_n`=0.
- R4: A full-word write takes place when `wr_all_n`=0, whatever the state of `wr_lane_en_n` and `lane_n`. It also takes place when `wr_all_n`=1, `wr_lane_en_n`=0 and `lane_n`=4'b0000.
- R5: With `wr_all_n`=1 and `wr_lane_en_n`=0, each bit i of `lane_n` that is 0 writes `din[8*i+7:8*i]`. Lanes whose bit is 1 keep their old contents.
- R6: With `wr_all_n`=1, an access is a read when `wr_lane_en_n`=1 or `lane_n`=4'b1111.
- R7: In a selected cycle that continues a burst with `adv_n`=0, only address bits [1:0] increment, modulo 4, and the upper bits stay fixed. After four such steps the address is back at the base.
- R8: In a burst-continuation cycle with `adv_n`=1, the same word is accessed again: it is read again or written again.
- R9: An address strobe during a burst loads the new `addr`, and the burst then continues from that address.
- R10: While `oe_n`=1, `dout_valid`=0 and `dout`=0. When `oe_n` returns to 0, pending read data shows again.
- R11: A deselected cycle ends the burst. `dout_valid` is 0 after the next edge. Selected cycles without a strobe make no access until a strobe starts a new burst.
- R12: After a write access edge, `dout_valid`=0 until a later read access.
- R13: After reset, `dout_valid`=0 and no burst is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | AW (8) | Word address |
| pstrb_n | input | 1 | Processor address strobe, active low |
| cstrb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| cs1_n | input | 1 | Chip select 1, active low |
| cs2 | input | 1 | Chip select 2, active high |
| cs3_n | input | 1 | Chip select 3, active low |
| wr_all_n | input | 1 | Full-word write, active low |
| wr_lane_en_n | input | 1 | Byte-lane write enable, active low |
| lane_n | input | LANES (4) | Byte-lane selects, active low |
| oe_n | input | 1 | Output enable, active low |
| din | input | 8*LANES (32) | Write data |
| dout | output | 8*LANES (32) | Read data, 0 when not valid |
| dout_valid | output | 1 | Output driven (not high impedance) |

## Verification
The bench first fills every word using single full-word writes through the controller strobe. It then drives single reads through each strobe, and bursts whose base sits at each position in the four-word group. This shows whether the address wraps inside the group or carries into the upper bits. Bursts with advance held high are mixed in, along with strobes in the middle of a burst and each of the three chip selects made invalid on its own; these separate holding from stepping, reloading from continuing, and which select term is decoded. Byte-lane masks, the full-word write with lane controls disabled, and a read disguised as a lane write check the write-control priority. A long run of pseudo-random cycles is then compared against the reference model on every clock.

// File: rtl/sync_burst_sram.sv
module sync_burst_sram #(
  parameter int DEPTH = 256,
  parameter int LANES = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int DW = 8 * LANES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             pstrb_n,
  input  logic             cstrb_n,
  input  logic             adv_n,
  input  logic             cs1_n,
  input  logic             cs2,
  input  logic             cs3_n,
  input  logic             wr_all_n,
  input  logic             wr_lane_en_n,
  input  logic [LANES-1:0] lane_n,
  input  logic             oe_n,
  input  logic [DW-1:0]    din,
  output logic [DW-1:0]    dout,
  output logic             dout_valid
);

  logic [DW-1:0]    mem [DEPTH];
  logic [DW-1:0]    rdata;
  logic             rvalid;
  logic             active;
  logic [AW-1:0]    cur_addr;
  logic [AW-1:0]    step_addr;
  logic [AW-1:0]    acc_addr;
  logic [LANES-1:0] wmask;
  logic             sel, start, acc, is_rd;

  assign sel       = ~cs1_n & cs2 & ~cs3_n;
  assign start     = sel & (~pstrb_n | ~cstrb_n);
  assign acc       = sel & (start | active);
  assign step_addr = {cur_addr[AW-1:2], cur_addr[1:0] + 2'd1};
  assign acc_addr  = start ? addr : (adv_n ? cur_addr : step_addr);
  assign wmask     = ~wr_all_n ? '1 : (~wr_lane_en_n ? ~lane_n : '0);
  assign is_rd     = acc & (wmask == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active   <= 1'b0;
      cur_addr <= '0;
      rvalid   <= 1'b0;
      rdata    <= '0;
    end else begin
      active <= acc;
      rvalid <= is_rd;
      if (acc) cur_addr <= acc_addr;
      if (is_rd) rdata <= mem[acc_addr];
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < LANES; i++)
      if (acc && wmask[i]) mem[acc_addr][8*i +: 8] <= din[8*i +: 8];
  end

  assign dout_valid = rvalid & ~oe_n;
  assign dout       = dout_valid ? rdata : '0;

  AST_DESEL_HIZ: assert property (@(posedge clk) disable iff (!rst_n)
    !sel |=> !dout_valid); // R11
  AST_LOAD_BASE: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> cur_addr == $past(addr)); // R9
  AST_HOLD_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !start && active && adv_n) |=> $stable(cur_addr)); // R8
  AST_UPPER_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && !start && active) |=> cur_addr[AW-1:2] == $past(cur_addr[AW-1:2])); // R7
  AST_WRITE_NO_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (!wr_all_n || (!wr_lane_en_n && lane_n != '1))) |=> !dout_valid); // R12
  AST_READ_SHOWS: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && (start || active) && wr_all_n && (wr_lane_en_n || lane_n == '1)) |=> (oe_n || dout_valid)); // R3

endmodule

// File: tb/sync_burst_sram_bench.sv
module sync_burst_sram_bench;
  logic clk = 0, rst_n = 0;
  logic [7:0] addr = 0;
  logic pstrb_n = 1, cstrb_n = 1, adv_n = 1, cs1_n = 0, cs2 = 1, cs3_n = 0;
  logic wr_all_n = 1, wr_lane_en_n = 1, oe_n = 0;
  logic [3:0] lane_n = 4'hF;
  logic [31:0] din = 0, dout;
  logic dout_valid;

  int checks = 0, errors = 0;
  logic [31:0] m_mem [256];
  logic m_act = 0, m_rv = 0;
  logic [7:0] m_cur = 0;
  logic [31:0] m_rd = 0;

  always #10 clk = ~clk;

  sync_burst_sram u_sync_burst_sram (
    .clk(clk), .rst_n(rst_n), .addr(addr), .pstrb_n(pstrb_n), .cstrb_n(cstrb_n),
    .adv_n(adv_n), .cs1_n(cs1_n), .cs2(cs2), .cs3_n(cs3_n), .wr_all_n(wr_all_n),
    .wr_lane_en_n(wr_lane_en_n), .lane_n(lane_n), .oe_n(oe_n), .din(din),
    .dout(dout), .dout_valid(dout_valid));

  task automatic compare(input string tag);
    logic ev;
    logic [31:0] ed;
    ev = m_rv && !oe_n;
    ed = ev ? m_rd : 32'h0;
    checks++;
    if (dout_valid !== ev || dout !== ed) begin
      errors++;
      $display("FAIL %s: dout_valid=%b dout=%h expected dout_valid=%b dout=%h",
               tag, dout_valid, dout, ev, ed);
    end
  endtask

  task automatic cyc(input string tag);
    logic sel, st, acc;
    logic [7:0] a;
    logic [3:0] wm;
    sel = !cs1_n && cs2 && !cs3_n;
    st = sel && (!pstrb_n || !cstrb_n);
    acc = 0; a = m_cur;
    if (sel && st) begin acc = 1; a = addr; end
    else if (sel && m_act) begin
      acc = 1;
      a = adv_n ? m_cur : ((m_cur & 8'hFC) | ((m_cur + 8'd1) & 8'h03));
    end
    wm = !wr_all_n ? 4'hF : (!wr_lane_en_n ? ~lane_n : 4'h0);
    @(posedge clk);
    m_act = acc;
    m_rv = acc && wm == 0;
    if (acc) begin
      m_cur = a;
      if (wm == 0) m_rd = m_mem[a];
      for (int i = 0; i < 4; i++) if (wm[i]) m_mem[a][8*i +: 8] = din[8*i +: 8];
    end
    #5;
    compare(tag);
  endtask

  task automatic idle();
    pstrb_n = 1; cstrb_n = 1; adv_n = 1; cs1_n = 0; cs2 = 1; cs3_n = 0;
    wr_all_n = 1; wr_lane_en_n = 1; lane_n = 4'hF; oe_n = 0;
  endtask

  task automatic rd_start(input string tag, input logic [7:0] a, input logic use_p);
    idle(); addr = a; pstrb_n = !use_p; cstrb_n = use_p; cyc(tag);
  endtask

  task automatic burst(input string tag, input int n, input logic adv);
    for (int i = 0; i < n; i++) begin idle(); adv_n = !adv; cyc(tag); end
  endtask

  initial begin
    #(20 * 200000);
    errors++; checks++;
    $display("FAIL watchdog: expired, expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    idle();
    #35; compare("R13");
    rst_n = 1;
    cyc("R13");
    for (int i = 0; i < 256; i++) begin
      idle(); addr = 8'(i); cstrb_n = 0; wr_all_n = 0; din = 32'hA5000000 ^ (i * 32'h01030507);
      cyc("R4");
    end
    idle(); cyc("R12");
    rd_start("R2", 8'h21, 1); idle(); cs1_n = 1; cyc("R3");
    rd_start("R2", 8'h42, 0); idle(); cs1_n = 1; cyc("R3");
    for (int b = 0; b < 4; b++) begin
      rd_start("R7", 8'h30 + 8'(b), b[0]); burst("R7", 5, 1);
    end
    rd_start("R8", 8'h55, 1); burst("R8", 3, 0); burst("R8", 2, 1);
    rd_start("R9", 8'h60, 0); burst("R9", 2, 1);
    idle(); addr = 8'h9E; pstrb_n = 0; adv_n = 0; cyc("R9"); burst("R9", 4, 1);
    rd_start("R10", 8'h10, 1); idle(); oe_n = 1; cyc("R10");
    idle(); oe_n = 1; cs2 = 0; cyc("R10"); idle(); cs2 = 0; #1 compare("R10");
    rd_start("R11", 8'h70, 1); idle(); cs2 = 0; cyc("R1"); burst("R11", 2, 1);
    rd_start("R11", 8'h71, 1); idle(); cs3_n = 1; cyc("R1");
    idle(); cs1_n = 1; pstrb_n = 0; addr = 8'h72; wr_all_n = 0; din = 32'hDEADBEEF; cyc("R2");
    idle(); cs1_n = 1; cstrb_n = 0; addr = 8'h72; wr_all_n = 0; cyc("R1");
    rd_start("R1", 8'h72, 0);
    for (int m = 0; m < 16; m++) begin
      idle(); addr = 8'h80; cstrb_n = 0; wr_lane_en_n = 0; lane_n = 4'(m);
      din = 32'h11223344 + 32'(m); cyc("R5");
      rd_start("R5", 8'h80, 1);
    end
    idle(); addr = 8'h81; cstrb_n = 0; wr_lane_en_n = 1; lane_n = 4'h0; din = 32'hCAFEF00D; cyc("R6");
    rd_start("R6", 8'h81, 0);
    idle(); addr = 8'h82; cstrb_n = 0; wr_all_n = 0; wr_lane_en_n = 1; lane_n = 4'hF; din = 32'h0BADC0DE; cyc("R4");
    rd_start("R4", 8'h82, 0);
    idle(); addr = 8'h84; cstrb_n = 0; wr_all_n = 0; din = 32'h1; cyc("R12");
    idle(); wr_all_n = 0; adv_n = 0; din = 32'h2; cyc("R12");
    idle(); wr_all_n = 0; din = 32'h3; cyc("R8");
    rd_start("R7", 8'h84, 1); burst("R7", 4, 1);
    for (int k = 0; k < 3000; k++) begin
      logic [31:0] r;
      r = $urandom;
      idle();
      addr = 8'($urandom); din = $urandom;
      pstrb_n = r[0] | r[1]; cstrb_n = r[2] | r[3]; adv_n = r[4];
      cs1_n = &r[7:5]; cs2 = |r[10:8]; cs3_n = &r[13:11];
      wr_all_n = |r[16:14]; wr_lane_en_n = r[17]; lane_n = r[21:18];
      oe_n = &r[23:22];
      cyc("R9");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule